// File: doc/BRIEF.md
# Flash Completion Status Poller

This block runs on the host side of a parallel NOR-style flash. After a program or erase command has been written to the device, the flash stays busy for a while. During that time, reading any location returns status encodings in data bits 7 and 6 rather than stored data.

The poller takes a start request. The request carries the operation kind, the word address to watch, and the word that was programmed. The poller then waits until the command issuer reports that the last write pulse of the command has ended. After that it issues single read cycles on a simple synchronous read port and judges each response.

Completion is detected in one of two ways, chosen by a build parameter:

- **Data-polling:** bit 7 is compared against the expected value.
- **Toggle-bit:** bit 7 is ignored, and the block watches whether bit 6 stops alternating.

Once a status read shows completion, the poller waits a settle interval of at least 1 µs, derived from the clock frequency. It then reads the whole word once more and reports it with a one-cycle done pulse. If completion is not seen within a configurable number of status reads, it raises a one-cycle timeout pulse instead and returns to idle.

Top module: `flash_done_poller`

## Requirements
- R1: A start request is accepted only while `busy` is low, and `busy` is high from the next cycle. A start request that arrives while `busy` is high changes neither the operation in progress nor its result.
- R2: No read request is issued until `cmdPulseDone` has been seen high in a cycle after the start was accepted.
- R3: Each read request is one cycle long. At most one read is outstanding. `rdAddr` holds the start address for the whole operation.
- R4: In data-polling mode (`USE_TOGGLE`=0), a status read shows completion as follows:
  - for a program operation (`startErase`=0), when its bit 7 equals bit 7 of `startData`;
  - for an erase operation (`startErase`=1), when its bit 7 is 1.
- R5: In toggle-bit mode (`USE_TOGGLE`=1), the first status read only records bit 6. A later status read shows completion when its bit 6 equals bit 6 of the status read just before it.
- R6: After the status response that shows completion, the final full-word read request is asserted exactly SETTLE_CYC+1 cycles later. SETTLE_CYC = ceil(CLK_FREQ_HZ / 1,000,000).
- R7: One cycle after the final read response, `done` is high for one cycle, `resultData` holds that response, and `busy` is low.
- R8: If MAX_POLLS status reads pass without completion, `timeout` pulses for one cycle and the block returns to idle. No further read is issued.
- R9: After reset, `busy`, `done`, `timeout` and `rdReq` are low. `done` and `timeout` are never high together, and each lasts a single cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startValid | input | 1 | Start request strobe |
| startErase | input | 1 | Operation kind: 1 erase, 0 program |
| startAddr | input | ADDR_W | Word address to poll |
| startData | input | DATA_W | Word that was programmed |
| cmdPulseDone | input | 1 | Last command write pulse has ended |
| rdReq | output | 1 | Read request, one cycle |
| rdAddr | output | ADDR_W | Read address |
| rdValid | input | 1 | Read response valid |
| rdData | input | DATA_W | Read response data |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Completion pulse |
| timeout | output | 1 | Poll limit reached pulse |
| resultData | output | DATA_W | Final full word read after settling |

## Verification
The bench runs a data-polling instance and a toggle-bit instance side by side against a flash model. The model returns busy status for a chosen number of reads, then true bits 7 and 6, with the other bits corrupted until the settle interval has passed.

The patterns vary four things:
- **Operation kind:** erase is started with an expected bit 7 of 0, so a program-rule decoder would finish at once.
- **Expected bit 7 value:** program words with bit 7 both 0 and 1 are used.
- **Number of busy reads:** this moves completion onto or past the poll limit.
- **Phase of bit 6 at completion:** the toggle instance needs one extra read in some cases. Some patterns therefore finish in one mode and time out in the other.

Read counts, the measured settle gap and the returned word show early completion, a missing settle and extra reads after a timeout. Delayed arming and a start request sent mid-operation cover gating and start rejection.

// File: rtl/flash_poll_pkg.sv
package flash_poll_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ARM,
    ST_ISSUE,
    ST_WAIT_STAT,
    ST_SETTLE,
    ST_FINAL_ISSUE,
    ST_WAIT_FINAL
  } pollState_t;

  typedef struct packed {
    logic loadCmd;
    logic sampleStatus;
    logic settleRun;
    logic captureFinal;
  } pollStrobes_t;

endpackage

// File: rtl/flash_poll_datapath.sv
module flash_poll_datapath
  import flash_poll_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int ADDR_W     = 20,
  parameter int MAX_POLLS  = 1024,
  parameter int SETTLE_CYC = 250,
  parameter int USE_TOGGLE = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  pollStrobes_t      strobes,
  input  logic              startErase,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic [DATA_W-1:0] startData,
  input  logic [DATA_W-1:0] rdData,
  output logic              statusHit,
  output logic              pollLast,
  output logic              settleDone,
  output logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] resultData
);

  localparam int POLL_W = $clog2(MAX_POLLS + 1);
  localparam int SET_W  = $clog2(SETTLE_CYC + 1);
  localparam int BIT_DP = 7;
  localparam int BIT_TG = 6;

  logic              eraseQ;
  logic              expBit7;
  logic [ADDR_W-1:0] addrQ;
  logic              firstRead;
  logic              lastBit6;
  logic [POLL_W-1:0] pollCnt;
  logic [SET_W-1:0]  settleCnt;
  logic [DATA_W-1:0] resultQ;
  logic              dataPollHit;
  logic              toggleHit;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      eraseQ    <= 1'b0;
      expBit7   <= 1'b0;
      addrQ     <= '0;
      firstRead <= 1'b1;
      lastBit6  <= 1'b0;
      pollCnt   <= '0;
      settleCnt <= '0;
      resultQ   <= '0;
    end else begin
      if (strobes.loadCmd) begin
        eraseQ    <= startErase;
        expBit7   <= startData[BIT_DP];
        addrQ     <= startAddr;
        firstRead <= 1'b1;
        pollCnt   <= '0;
        settleCnt <= '0;
      end
      if (strobes.sampleStatus) begin
        firstRead <= 1'b0;
        lastBit6  <= rdData[BIT_TG];
        pollCnt   <= pollCnt + 1'b1;
        settleCnt <= '0;
      end
      if (strobes.settleRun) begin
        settleCnt <= settleCnt + 1'b1;
      end
      if (strobes.captureFinal) begin
        resultQ <= rdData;
      end
    end
  end

  // Inverted-data rule for program, fixed-one rule for erase.
  assign dataPollHit = eraseQ ? rdData[BIT_DP] : (rdData[BIT_DP] == expBit7);
  // Alternating-bit rule: two equal consecutive samples mean the device is idle.
  assign toggleHit   = !firstRead && (rdData[BIT_TG] == lastBit6);

  generate
    if (USE_TOGGLE != 0) begin : g_toggle
      assign statusHit = toggleHit;
    end else begin : g_datapoll
      assign statusHit = dataPollHit;
    end
  endgenerate

  assign pollLast   = (pollCnt == POLL_W'(MAX_POLLS - 1));
  assign settleDone = (settleCnt == SET_W'(SETTLE_CYC - 1));
  assign rdAddr     = addrQ;
  assign resultData = resultQ;

endmodule

// File: rtl/flash_poll_ctrl.sv
module flash_poll_ctrl
  import flash_poll_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         startValid,
  input  logic         cmdPulseDone,
  input  logic         rdValid,
  input  logic         statusHit,
  input  logic         pollLast,
  input  logic         settleDone,
  output pollStrobes_t strobes,
  output logic         rdReq,
  output logic         busy,
  output logic         done,
  output logic         timeout
);

  pollState_t state, stateNext;
  logic       doneSet, timeoutSet;
  logic       doneQ, timeoutQ;

  always_comb begin
    stateNext  = state;
    strobes    = '0;
    doneSet    = 1'b0;
    timeoutSet = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (startValid) begin
          strobes.loadCmd = 1'b1;
          stateNext       = ST_ARM;
        end
      end
      ST_ARM: begin
        if (cmdPulseDone) stateNext = ST_ISSUE;
      end
      ST_ISSUE: stateNext = ST_WAIT_STAT;
      ST_WAIT_STAT: begin
        if (rdValid) begin
          strobes.sampleStatus = 1'b1;
          if (statusHit) begin
            stateNext = ST_SETTLE;
          end else if (pollLast) begin
            timeoutSet = 1'b1;
            stateNext  = ST_IDLE;
          end else begin
            stateNext = ST_ISSUE;
          end
        end
      end
      ST_SETTLE: begin
        strobes.settleRun = 1'b1;
        if (settleDone) stateNext = ST_FINAL_ISSUE;
      end
      ST_FINAL_ISSUE: stateNext = ST_WAIT_FINAL;
      ST_WAIT_FINAL: begin
        if (rdValid) begin
          strobes.captureFinal = 1'b1;
          doneSet              = 1'b1;
          stateNext            = ST_IDLE;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      doneQ    <= 1'b0;
      timeoutQ <= 1'b0;
    end else begin
      state    <= stateNext;
      doneQ    <= doneSet;
      timeoutQ <= timeoutSet;
    end
  end

  assign rdReq   = (state == ST_ISSUE) || (state == ST_FINAL_ISSUE);
  assign busy    = (state != ST_IDLE);
  assign done    = doneQ;
  assign timeout = timeoutQ;

endmodule

// File: rtl/flash_done_poller.sv
module flash_done_poller
  import flash_poll_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int ADDR_W      = 20,
  parameter int CLK_FREQ_HZ = 250_000_000,
  parameter int MAX_POLLS   = 1024,
  parameter int USE_TOGGLE  = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startValid,
  input  logic              startErase,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic [DATA_W-1:0] startData,
  input  logic              cmdPulseDone,
  output logic              rdReq,
  output logic [ADDR_W-1:0] rdAddr,
  input  logic              rdValid,
  input  logic [DATA_W-1:0] rdData,
  output logic              busy,
  output logic              done,
  output logic              timeout,
  output logic [DATA_W-1:0] resultData
);

  localparam int SETTLE_CYC = (CLK_FREQ_HZ + 999_999) / 1_000_000;

  pollStrobes_t strobes;
  logic         statusHit;
  logic         pollLast;
  logic         settleDone;

  flash_poll_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .startValid   (startValid),
    .cmdPulseDone (cmdPulseDone),
    .rdValid      (rdValid),
    .statusHit    (statusHit),
    .pollLast     (pollLast),
    .settleDone   (settleDone),
    .strobes      (strobes),
    .rdReq        (rdReq),
    .busy         (busy),
    .done         (done),
    .timeout      (timeout)
  );

  flash_poll_datapath #(
    .DATA_W     (DATA_W),
    .ADDR_W     (ADDR_W),
    .MAX_POLLS  (MAX_POLLS),
    .SETTLE_CYC (SETTLE_CYC),
    .USE_TOGGLE (USE_TOGGLE)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .startErase (startErase),
    .startAddr  (startAddr),
    .startData  (startData),
    .rdData     (rdData),
    .statusHit  (statusHit),
    .pollLast   (pollLast),
    .settleDone (settleDone),
    .rdAddr     (rdAddr),
    .resultData (resultData)
  );

endmodule

// File: rtl/flash_done_poller_chk.sv
module flash_done_poller_chk #(
  parameter int ADDR_W    = 20,
  parameter int MAX_POLLS = 1024
) (
  input logic              clk,
  input logic              rstN,
  input logic              startValid,
  input logic              cmdPulseDone,
  input logic              rdReq,
  input logic [ADDR_W-1:0] rdAddr,
  input logic              rdValid,
  input logic              busy,
  input logic              done,
  input logic              timeout
);

  localparam int CW = $clog2(MAX_POLLS + 3);

  logic          armed;
  logic          pend;
  logic [CW-1:0] reqCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      armed  <= 1'b0;
      pend   <= 1'b0;
      reqCnt <= '0;
    end else begin
      if (!busy)             armed <= 1'b0;
      else if (cmdPulseDone) armed <= 1'b1;
      if (rdReq)        pend <= 1'b1;
      else if (rdValid) pend <= 1'b0;
      if (!busy) reqCnt <= '0;
      else if (rdReq && (int'(reqCnt) < MAX_POLLS + 2)) reqCnt <= reqCnt + 1'b1;
    end
  end

  p_start_busy_r1: assert property (@(posedge clk) disable iff (!rstN)
    (startValid && !busy) |=> busy);

  p_arm_gate_r2: assert property (@(posedge clk) disable iff (!rstN)
    rdReq |-> armed);

  p_one_outstanding_r3: assert property (@(posedge clk) disable iff (!rstN)
    rdReq |-> !pend);

  p_addr_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> $stable(rdAddr));

  p_end_idle_r7: assert property (@(posedge clk) disable iff (!rstN)
    (done || timeout) |-> !busy);

  p_poll_bound_r8: assert property (@(posedge clk) disable iff (!rstN)
    int'(reqCnt) <= MAX_POLLS + 1);

  p_exclusive_r9: assert property (@(posedge clk) disable iff (!rstN)
    !(done && timeout));

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  p_timeout_pulse_r9: assert property (@(posedge clk) disable iff (!rstN)
    timeout |=> !timeout);

endmodule

bind flash_done_poller flash_done_poller_chk #(
  .ADDR_W    (ADDR_W),
  .MAX_POLLS (MAX_POLLS)
) u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .startValid   (startValid),
  .cmdPulseDone (cmdPulseDone),
  .rdReq        (rdReq),
  .rdAddr       (rdAddr),
  .rdValid      (rdValid),
  .busy         (busy),
  .done         (done),
  .timeout      (timeout)
);

// File: tb/flash_done_poller_tb.sv
`timescale 1ns/1ps

module flash_status_model #(
  parameter int SETTLE = 250
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        load,
  input  logic        loadErase,
  input  logic [15:0] loadData,
  input  logic [7:0]  loadBusy,
  input  logic [19:0] expAddr,
  input  logic        rdReq,
  input  logic [19:0] rdAddr,
  output logic        rdValid,
  output logic [15:0] rdData,
  output int          readCnt,
  output int          lastGap,
  output logic        addrErr
);
  logic        eraseM;
  logic [15:0] dataM;
  logic [7:0]  busyLeft;
  logic        tog;
  logic        doneSeen;
  int          doneCyc;
  int          cyc;
  int          lastValidCyc;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdValid <= 1'b0; rdData <= '0; readCnt <= 0; lastGap <= 0; addrErr <= 1'b0;
      eraseM <= 1'b0; dataM <= '0; busyLeft <= '0; tog <= 1'b1; doneSeen <= 1'b0;
      doneCyc <= 0; cyc <= 0; lastValidCyc <= 0;
    end else begin
      cyc <= cyc + 1;
      if (rdValid) lastValidCyc <= cyc;
      if (load) begin
        eraseM <= loadErase; dataM <= loadData; busyLeft <= loadBusy;
        tog <= 1'b1; doneSeen <= 1'b0; readCnt <= 0; addrErr <= 1'b0;
        rdValid <= 1'b0;
      end else if (rdReq) begin
        rdValid <= 1'b1;
        readCnt <= readCnt + 1;
        lastGap <= cyc - lastValidCyc;
        if (rdAddr != expAddr) addrErr <= 1'b1;
        if (busyLeft != 0) begin
          busyLeft <= busyLeft - 1'b1;
          tog      <= ~tog;
          rdData   <= {~dataM[15:8], (eraseM ? 1'b0 : ~dataM[7]), tog, ~dataM[5:0]};
        end else begin
          if (!doneSeen) begin
            doneSeen <= 1'b1;
            doneCyc  <= cyc;
          end
          if (!doneSeen || (cyc < doneCyc + SETTLE))
            rdData <= {~dataM[15:8], dataM[7:6], ~dataM[5:0]};
          else
            rdData <= dataM;
        end
      end else begin
        rdValid <= 1'b0;
      end
    end
  end
endmodule

module flash_done_poller_tb;
  localparam int MAXP = 8;
  localparam int SET  = 250;

  typedef struct packed {
    logic        erase;
    logic [15:0] expData;
    logic [15:0] devData;
    logic [7:0]  busyReads;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 16'h1234, 16'h1234, 8'd3},
    '{1'b0, 16'hBEEF, 16'hBEEF, 8'd0},
    '{1'b1, 16'h0000, 16'hFFFF, 8'd5},
    '{1'b0, 16'h5A5A, 16'h5A5A, 8'd7},
    '{1'b0, 16'h3C3C, 16'h3C3C, 8'd7},
    '{1'b1, 16'h0000, 16'hFFFF, 8'd20},
    '{1'b0, 16'h8040, 16'h8040, 8'd1}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2 clk = ~clk;

  logic        startValid = 1'b0;
  logic        startErase = 1'b0;
  logic [19:0] startAddr = '0;
  logic [15:0] startData = '0;
  logic        cmdPulseDone = 1'b0;
  logic        load = 1'b0;
  logic        loadErase = 1'b0;
  logic [15:0] loadData = '0;
  logic [7:0]  loadBusy = '0;

  logic        rdReqA, rdReqB, rdValidA, rdValidB, busyA, busyB;
  logic        doneA, doneB, toA, toB;
  logic [19:0] rdAddrA, rdAddrB;
  logic [15:0] rdDataA, rdDataB, resA, resB;
  int          readCntA, readCntB, gapA, gapB;
  logic        addrErrA, addrErrB;

  flash_done_poller #(.MAX_POLLS(MAXP), .USE_TOGGLE(0)) u_dut (
    .clk(clk), .rstN(rstN), .startValid(startValid), .startErase(startErase),
    .startAddr(startAddr), .startData(startData), .cmdPulseDone(cmdPulseDone),
    .rdReq(rdReqA), .rdAddr(rdAddrA), .rdValid(rdValidA), .rdData(rdDataA),
    .busy(busyA), .done(doneA), .timeout(toA), .resultData(resA));

  flash_done_poller #(.MAX_POLLS(MAXP), .USE_TOGGLE(1)) u_dutTgl (
    .clk(clk), .rstN(rstN), .startValid(startValid), .startErase(startErase),
    .startAddr(startAddr), .startData(startData), .cmdPulseDone(cmdPulseDone),
    .rdReq(rdReqB), .rdAddr(rdAddrB), .rdValid(rdValidB), .rdData(rdDataB),
    .busy(busyB), .done(doneB), .timeout(toB), .resultData(resB));

  flash_status_model #(.SETTLE(SET)) u_memA (
    .clk(clk), .rstN(rstN), .load(load), .loadErase(loadErase), .loadData(loadData),
    .loadBusy(loadBusy), .expAddr(startAddr), .rdReq(rdReqA), .rdAddr(rdAddrA),
    .rdValid(rdValidA), .rdData(rdDataA), .readCnt(readCntA), .lastGap(gapA),
    .addrErr(addrErrA));

  flash_status_model #(.SETTLE(SET)) u_memB (
    .clk(clk), .rstN(rstN), .load(load), .loadErase(loadErase), .loadData(loadData),
    .loadBusy(loadBusy), .expAddr(startAddr), .rdReq(rdReqB), .rdAddr(rdAddrB),
    .rdValid(rdValidB), .rdData(rdDataB), .readCnt(readCntB), .lastGap(gapB),
    .addrErr(addrErrB));

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  int doneCntA = 0, doneCntB = 0, toCntA = 0, toCntB = 0;
  logic [15:0] gotA = '0, gotB = '0;

  always @(negedge clk) begin
    if (doneA) begin doneCntA++; gotA = resA; end
    if (doneB) begin doneCntB++; gotB = resB; end
    if (toA) toCntA++;
    if (toB) toCntB++;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      failures++;
      $display("FAIL watchdog R7 actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int readsDp(vec_t v);
    return int'(v.busyReads) + 1;
  endfunction

  function automatic int readsTg(vec_t v);
    int b;
    logic lastBusy;
    b = int'(v.busyReads);
    if (b == 0) return 2;
    lastBusy = 1'b1 ^ logic'((b - 1) & 1);
    return (v.devData[6] == lastBusy) ? b + 1 : b + 2;
  endfunction

  task automatic runOp(input vec_t v, input logic [19:0] addr, input int armDelay,
                       input bit interfere);
    @(negedge clk);
    doneCntA = 0; doneCntB = 0; toCntA = 0; toCntB = 0; gotA = '0; gotB = '0;
    startValid = 1'b1; startErase = v.erase; startAddr = addr; startData = v.expData;
    load = 1'b1; loadErase = v.erase; loadData = v.devData; loadBusy = v.busyReads;
    @(negedge clk);
    startValid = 1'b0; load = 1'b0;
    check("R1 busy after start (data-poll)", 32'(busyA), 32'd1);
    repeat (armDelay) @(negedge clk);
    if (armDelay > 0) begin
      check("R2 no read before arm (data-poll)", 32'(readCntA), 32'd0);
      check("R2 no read before arm (toggle)", 32'(readCntB), 32'd0);
    end
    cmdPulseDone = 1'b1;
    @(negedge clk);
    cmdPulseDone = 1'b0;
    if (interfere) begin
      repeat (3) @(negedge clk);
      startValid = 1'b1; startErase = ~v.erase; startData = ~v.expData;
      startAddr = addr ^ 20'h00F0F;
      @(negedge clk);
      startValid = 1'b0; startAddr = addr;
    end
    for (int i = 0; i < 5000 && (busyA || busyB); i++) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic checkDut(input string nm, input int reads, input int doneCnt,
                          input int toCnt, input logic [15:0] got, input int rdCnt,
                          input int gap, input logic aErr, input vec_t v);
    if (reads <= MAXP) begin
      check({"R4/R5 completion detected ", nm}, 32'(doneCnt), 32'd1);
      check({"R8 no timeout ", nm}, 32'(toCnt), 32'd0);
      check({"R7 result word ", nm}, 32'(got), 32'(v.devData));
      check({"R4/R5 status read count ", nm}, 32'(rdCnt), 32'(reads + 1));
      check({"R6 settle gap ", nm}, 32'(gap), 32'(SET + 1));
    end else begin
      check({"R8 timeout pulse ", nm}, 32'(toCnt), 32'd1);
      check({"R9 no done on timeout ", nm}, 32'(doneCnt), 32'd0);
      check({"R8 reads stop at limit ", nm}, 32'(rdCnt), 32'(MAXP));
    end
    check({"R3 read address ", nm}, 32'(aErr), 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R9 reset busy", 32'({busyA, busyB}), 32'd0);
    check("R9 reset done/timeout", 32'({doneA, doneB, toA, toB}), 32'd0);
    check("R9 reset rdReq", 32'({rdReqA, rdReqB}), 32'd0);

    for (int k = 0; k < NV; k++) begin
      runOp(VECS[k], 20'h01000 + 20'(k), 0, 1'b0);
      checkDut("data-poll", readsDp(VECS[k]), doneCntA, toCntA, gotA, readCntA, gapA,
               addrErrA, VECS[k]);
      checkDut("toggle", readsTg(VECS[k]), doneCntB, toCntB, gotB, readCntB, gapB,
               addrErrB, VECS[k]);
    end

    // R2: a long wait for the last command pulse issues no read.
    runOp(VECS[0], 20'h2ABCD, 20, 1'b0);
    checkDut("data-poll armed late", readsDp(VECS[0]), doneCntA, toCntA, gotA, readCntA,
             gapA, addrErrA, VECS[0]);

    // R1: a start request mid-operation is ignored.
    runOp(VECS[2], 20'h3F00F, 2, 1'b1);
    checkDut("data-poll restart ignored R1", readsDp(VECS[2]), doneCntA, toCntA, gotA,
             readCntA, gapA, addrErrA, VECS[2]);
    checkDut("toggle restart ignored R1", readsTg(VECS[2]), doneCntB, toCntB, gotB,
             readCntB, gapB, addrErrB, VECS[2]);
    check("R1 idle after ignored start", 32'({busyA, busyB}), 32'd0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule